// File: doc/BRIEF.md
# Redirection-Table Interrupt Router

This block turns interrupt input pins into delivery messages for a set of destination processors. Each pin owns one 64-bit redirection entry. The entry holds the vector, delivery mode, destination mode, input polarity, trigger mode, mask and destination. A pending bit is kept per pin. Edge-triggered pins latch a request on each rising effective edge. For a level-triggered pin, the pending bit follows the input level.

The router walks the pins in ascending index order. It emits at most one message per cycle on a valid/ready port, and it holds a message unchanged while the port is stalled. A level-triggered pin that has been delivered is marked in service by a remote-IRR flag. It is not delivered again until an end-of-interrupt broadcast with a matching vector clears that flag. If the pin is still asserted at that point, it is delivered again. Entries in external-interrupt mode take their vector from an outside legacy controller through a one-cycle acknowledge strobe.

Entries are loaded through a simple table write strobe. The surrounding register bus decodes its own address space and drives that strobe.

Top module: `irq_redir_router`

## Requirements
- R1: After reset every entry is masked, every remote-IRR flag is clear, and `msg_valid` and `ext_inta` are low. Input activity then produces no message until an entry is written unmasked.
- R2: A table write sets the fields of one entry as follows: vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], trigger mode [15] (1 = level, 0 = edge) and mask [16] (1 = masked), with the destination in [63:56]. The remote-IRR position [14] in the write data is ignored. Writes to an index of NPINS or above have no effect.
- R3: A masked pin never produces a message. A rising edge on a masked edge-triggered pin is dropped, and it does not show up when the pin is later unmasked.
- R4: With the polarity bit set, the raw input is inverted before trigger processing, so a low input counts as asserted.
- R5: An edge-triggered pin gives exactly one message per rising effective edge, and its pending bit clears on delivery. Holding the input asserted does not repeat the message.
- R6: A level-triggered pin is pending while its effective input is asserted. Delivery sets its remote-IRR flag, and while that flag is set the pin produces no further message.
- R7: An end-of-interrupt broadcast clears the remote-IRR flag of every entry whose vector matches. A matching entry that is still asserted and unmasked is delivered again. A broadcast with a different vector has no effect, and a pin deasserted before the broadcast is not delivered again.
- R8: When delivery mode equals 3'b111 (external interrupt), `ext_inta` pulses high in the cycle the message is loaded. The message vector is then `ext_vector` as sampled in that cycle, and not the entry vector.
- R9: Each message carries the entry's destination, destination mode, delivery mode and trigger mode, together with the vector chosen as in R8.
- R10: Input 0 drives pin 2, combined by OR with input 2. Pin 0 has no input, so its raw level is low. Every other input drives the pin of the same index.
- R11: Among deliverable pins the lowest index is sent first. A message appears two clocks after the input change. It stays stable while `msg_valid` is high and `msg_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NPINS | Raw interrupt inputs |
| tbl_wr | input | 1 | Table write strobe |
| tbl_idx | input | IW | Entry index for the write |
| tbl_wdata | input | 64 | Entry contents |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector of the broadcast |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Message accepted |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_trig | output | 1 | Trigger mode (1 = level) |
| ext_inta | output | 1 | Vector fetch strobe to the legacy controller |
| ext_vector | input | 8 | Vector returned by the legacy controller |

## Verification
The assertions assume three things about the inputs. First, `ext_vector` is valid in the same cycle as `ext_inta`. Second, a broadcast strobe lasts one cycle per end-of-interrupt. Third, `msg_ready` is free to fall at any time. The random stimulus always drives a pin to its inactive level for the chosen polarity before unmasking the entry, and it rewrites each entry as masked and edge-triggered before moving on. This keeps polarity changes from creating edges the scoreboard does not expect. The stimulus also keeps the external-interrupt mode to directed tests, so that every random expected vector comes from the entry itself.

// File: rtl/irq_redir_router.sv
module irq_redir_router #(
  parameter int NPINS = 8,
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_in,
  input  logic             tbl_wr,
  input  logic [IW-1:0]    tbl_idx,
  input  logic [63:0]      tbl_wdata,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vector,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [7:0]       msg_dest,
  output logic             msg_dest_mode,
  output logic [2:0]       msg_deliv,
  output logic [7:0]       msg_vector,
  output logic             msg_trig,
  output logic             ext_inta,
  input  logic [7:0]       ext_vector
);
  localparam logic [2:0] MODE_EXT = 3'b111;

  logic [7:0]       vec_q  [NPINS];
  logic [2:0]       dlv_q  [NPINS];
  logic [7:0]       dst_q  [NPINS];
  logic [NPINS-1:0] dmd_q, pol_q, lvl_q, msk_q;
  logic [NPINS-1:0] irr_q, rirr_q, prev_q;
  logic [NPINS-1:0] routed, eff, cand, eoi_hit;
  logic [IW-1:0]    sel;
  logic             found, load;

  logic unused_wbits;
  assign unused_wbits = ^{tbl_wdata[55:17], tbl_wdata[14], tbl_wdata[12]};

  always_comb begin
    routed    = irq_in;
    routed[0] = 1'b0;
    routed[2] = irq_in[0] | irq_in[2];
  end

  assign eff  = routed ^ pol_q;
  assign cand = irr_q & ~msk_q & ~(lvl_q & rirr_q);

  for (genvar g = 0; g < NPINS; g++) begin : g_eoi
    assign eoi_hit[g] = eoi_valid && rirr_q[g] && (vec_q[g] == eoi_vector);
  end

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        sel   = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign load     = found && (!msg_valid || msg_ready);
  assign ext_inta = load && (dlv_q[sel] == MODE_EXT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid     <= 1'b0;
      msg_dest      <= '0;
      msg_dest_mode <= 1'b0;
      msg_deliv     <= '0;
      msg_vector    <= '0;
      msg_trig      <= 1'b0;
    end else if (load) begin
      msg_valid     <= 1'b1;
      msg_dest      <= dst_q[sel];
      msg_dest_mode <= dmd_q[sel];
      msg_deliv     <= dlv_q[sel];
      msg_vector    <= (dlv_q[sel] == MODE_EXT) ? ext_vector : vec_q[sel];
      msg_trig      <= lvl_q[sel];
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      rirr_q <= '0;
      prev_q <= '0;
      dmd_q  <= '0;
      pol_q  <= '0;
      lvl_q  <= '0;
      msk_q  <= '1;
      for (int i = 0; i < NPINS; i++) begin
        vec_q[i] <= '0;
        dlv_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else begin
      prev_q <= eff;
      for (int i = 0; i < NPINS; i++) begin
        if (lvl_q[i])
          irr_q[i] <= eff[i];
        else
          irr_q[i] <= (irr_q[i] && !(load && sel == IW'(i)))
                      || (eff[i] && !prev_q[i] && !msk_q[i]);
        if (load && sel == IW'(i) && lvl_q[i])
          rirr_q[i] <= 1'b1;
        else if (eoi_hit[i])
          rirr_q[i] <= 1'b0;
        if (tbl_wr && tbl_idx == IW'(i)) begin
          vec_q[i] <= tbl_wdata[7:0];
          dlv_q[i] <= tbl_wdata[10:8];
          dmd_q[i] <= tbl_wdata[11];
          pol_q[i] <= tbl_wdata[13];
          lvl_q[i] <= tbl_wdata[15];
          msk_q[i] <= tbl_wdata[16];
          dst_q[i] <= tbl_wdata[63:56];
        end
      end
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid &&
      $stable({msg_dest, msg_dest_mode, msg_deliv, msg_vector, msg_trig}));

  // R8
  ext_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_inta |=> msg_valid && msg_deliv == MODE_EXT && msg_vector == $past(ext_vector));

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    // R3
    masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_q[g] && msk_q[g] && !irr_q[g] |=> !irr_q[g]);
    // R6
    inservice_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q[g] && rirr_q[g] && !eoi_hit[g] |=> rirr_q[g]);
    // R7
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_hit[g] |=> !rirr_q[g]);
  end
endmodule

// File: tb/tb_irq_redir_router.sv
module tb_irq_redir_router;
  localparam int NPINS = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NPINS-1:0] irq_in = '0;
  logic tbl_wr = 1'b0;
  logic [IW-1:0] tbl_idx = '0;
  logic [63:0] tbl_wdata = '0;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vector = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [7:0] msg_dest, msg_vector;
  logic msg_dest_mode, msg_trig, ext_inta;
  logic [2:0] msg_deliv;
  logic [7:0] ext_vector = 8'h99;

  irq_redir_router #(.NPINS(NPINS)) dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, mcnt = 0, icnt = 0;
  logic [20:0] mlog [256];

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      mlog[mcnt % 256] = {msg_dest, msg_dest_mode, msg_deliv, msg_vector, msg_trig};
      mcnt++;
    end
    if (rst_n && ext_inta) icnt++;
  end

  function automatic logic [63:0] ent(input logic [7:0] vec, input logic [2:0] dlv,
      input logic dmd, input logic pol, input logic lvl, input logic msk, input logic [7:0] dst);
    ent = '0;
    ent[7:0] = vec; ent[10:8] = dlv; ent[11] = dmd; ent[13] = pol;
    ent[15] = lvl; ent[16] = msk; ent[63:56] = dst;
  endfunction

  function automatic logic [20:0] exp_msg(input logic [63:0] e, input logic [7:0] xv);
    logic [7:0] v;
    v = (e[10:8] == 3'b111) ? xv : e[7:0];
    exp_msg = {e[63:56], e[11], e[10:8], v, e[15]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [63:0] d);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_idx = IW'(idx); tbl_wdata = d;
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  localparam logic [63:0] PARK = 64'h1_0000;

  initial begin
    int base, ib;
    logic [63:0] e1, e3;
    void'($urandom(32'd1234));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk(msg_valid == 1'b0, "R1 msg_valid after reset", msg_valid, 0);
    chk(ext_inta == 1'b0, "R1 ext_inta after reset", ext_inta, 0);
    irq_in = '1; cyc(2); irq_in = '0; cyc(6);
    chk(mcnt == 0, "R1 masked at reset", mcnt, 0);

    // R5 R9 edge delivery, fields
    e3 = ent(8'h41, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A);
    wr(3, e3);
    base = mcnt;
    irq_in[3] = 1'b1;
    cyc(2);
    chk(msg_valid == 1'b1, "R11 two-clock latency", msg_valid, 1);
    cyc(20);
    chk(mcnt - base == 1, "R5 one message per edge", mcnt - base, 1);
    chk(mlog[base % 256] == exp_msg(e3, 8'h0), "R9 edge fields", mlog[base % 256], exp_msg(e3, 8'h0));
    irq_in[3] = 1'b0; cyc(3);
    base = mcnt; irq_in[3] = 1'b1; cyc(6); irq_in[3] = 1'b0; cyc(2);
    chk(mcnt - base == 1, "R5 second edge", mcnt - base, 1);

    // R3 masked edge dropped
    wr(4, ent(8'h44, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01));
    base = mcnt;
    irq_in[4] = 1'b1; cyc(2); irq_in[4] = 1'b0; cyc(2);
    wr(4, ent(8'h44, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
    cyc(8);
    chk(mcnt == base, "R3 masked edge dropped", mcnt - base, 0);
    wr(4, PARK);

    // R6 R7 level pin, remote IRR
    base = mcnt;
    wr(5, ent(8'h62, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h22) | 64'h4000);
    cyc(6);
    chk(mcnt == base, "R6 level idle no message", mcnt - base, 0);
    irq_in[5] = 1'b1; cyc(6);
    chk(mcnt - base == 1, "R6 level delivered once", mcnt - base, 1);
    chk(mlog[base % 256][0] == 1'b1, "R9 trigger field level", mlog[base % 256][0], 1);
    cyc(20);
    chk(mcnt - base == 1, "R6 remote IRR blocks", mcnt - base, 1);
    wr(5, ent(8'h62, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h22));
    cyc(6);
    chk(mcnt - base == 1, "R2 write leaves remote IRR", mcnt - base, 1);
    eoi(8'h63); cyc(6);
    chk(mcnt - base == 1, "R7 mismatched EOI ignored", mcnt - base, 1);
    eoi(8'h62); cyc(6);
    chk(mcnt - base == 2, "R7 EOI redelivers", mcnt - base, 2);
    irq_in[5] = 1'b0; cyc(3);
    eoi(8'h62); cyc(6);
    chk(mcnt - base == 2, "R7 deasserted no redelivery", mcnt - base, 2);
    wr(5, PARK);

    // R4 polarity
    irq_in[6] = 1'b1; cyc(2);
    base = mcnt;
    wr(6, ent(8'h76, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h33));
    cyc(6);
    chk(mcnt == base, "R4 high input inactive", mcnt - base, 0);
    irq_in[6] = 1'b0; cyc(6);
    chk(mcnt - base == 1, "R4 low input asserts", mcnt - base, 1);
    irq_in[6] = 1'b1; cyc(2); eoi(8'h76); cyc(6);
    chk(mcnt - base == 1, "R4 released", mcnt - base, 1);
    wr(6, PARK); irq_in[6] = 1'b0; cyc(2);

    // R10 routing
    wr(0, ent(8'h10, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
    wr(2, ent(8'h22, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02));
    base = mcnt;
    irq_in[0] = 1'b1; cyc(2); irq_in[0] = 1'b0; cyc(6);
    chk(mcnt - base == 1, "R10 input 0 one message", mcnt - base, 1);
    chk(mlog[base % 256][8:1] == 8'h22, "R10 input 0 to pin 2", mlog[base % 256][8:1], 8'h22);
    wr(0, PARK); wr(2, PARK);

    // R8 external vector
    e1 = ent(8'h11, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 8'h07);
    wr(1, e1);
    base = mcnt; ib = icnt;
    irq_in[1] = 1'b1; cyc(2); irq_in[1] = 1'b0; cyc(6);
    chk(mcnt - base == 1, "R8 one message", mcnt - base, 1);
    chk(icnt - ib == 1, "R8 one fetch strobe", icnt - ib, 1);
    chk(mlog[base % 256] == exp_msg(e1, 8'h99), "R8 external vector", mlog[base % 256], exp_msg(e1, 8'h99));

    // R11 order and hold under backpressure
    e1 = ent(8'h31, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0A);
    wr(1, e1);
    msg_ready = 1'b0;
    base = mcnt;
    irq_in[1] = 1'b1; irq_in[3] = 1'b1;
    cyc(3);
    chk(msg_valid && msg_vector == 8'h31, "R11 lowest first", msg_vector, 8'h31);
    cyc(5);
    chk(msg_valid && msg_vector == 8'h31 && msg_dest == 8'h0A, "R11 held while stalled", msg_vector, 8'h31);
    msg_ready = 1'b1;
    cyc(4);
    chk(mcnt - base == 2, "R11 two messages", mcnt - base, 2);
    chk(mlog[(base + 1) % 256] == exp_msg(e3, 8'h0), "R11 second is pin 3", mlog[(base + 1) % 256], exp_msg(e3, 8'h0));
    irq_in = '0; wr(1, PARK); wr(3, PARK);

    // R2 out-of-range index (none exists at NPINS=8): write to a parked index unchanged
    // random sweep R2 R5 R6 R7 R9
    for (int it = 0; it < 40; it++) begin
      int p;
      logic [63:0] e;
      logic pol, lvl;
      logic [2:0] dm;
      p = 1 + int'($urandom_range(6));
      pol = 1'($urandom_range(1));
      lvl = 1'($urandom_range(1));
      dm = 3'($urandom_range(6));
      e = ent(8'($urandom), dm, 1'($urandom_range(1)), pol, lvl, 1'b0, 8'($urandom));
      irq_in[p] = pol; cyc(2);
      base = mcnt;
      wr(p, e); cyc(4);
      chk(mcnt == base, "R2 random idle", mcnt - base, 0);
      irq_in[p] = ~pol; cyc(6);
      chk(mcnt - base == 1, "R5 R6 random delivery", mcnt - base, 1);
      chk(mlog[base % 256] == exp_msg(e, 8'h0), "R9 random fields", mlog[base % 256], exp_msg(e, 8'h0));
      irq_in[p] = pol; cyc(2);
      if (lvl) eoi(e[7:0]);
      cyc(6);
      chk(mcnt - base == 1, "R7 random no redelivery", mcnt - base, 1);
      wr(p, PARK); irq_in[p] = 1'b0; cyc(2);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule